// File: doc/BRIEF.md
# Dispatch Group Slot Gate

This block sits in the decode stage of a superscalar front end. For each decoded instruction it is shown, it decides in the same cycle whether that instruction may join the dispatch group being built. A descriptor enters as a valid bit, a five-bit flag word and two control-transfer hints. The flag word carries an execution unit class and two placement flags. The two hints say whether the instruction writes the count register and whether it branches indirectly through that register.

The gate answers with exactly one of three results. It can accept the instruction. It can report a hazard, so the instruction waits for a fresh group. Or it can ask for a no-op to be inserted, so that a count-register write and a branch through that register never share a group. The gate also shows how many slots of the current group are filled.

Internally it keeps a slot counter and a flag noting that the count register was written in this group. It closes the group when the last slot fills, when a branch or a must-be-alone instruction issues, or when the scheduler advances a cycle.

Top module: `dgrp_gate`

## Requirements
- R1: After reset `slot_count` is 0 and no count-register write is recorded, so an indirect branch through the count register is accepted as the first instruction.
- R2: A class-0 (pseudo) instruction is always accepted, whatever its placement flags. It raises neither a hazard nor a no-op request, and `slot_count` is unchanged on the next cycle.
- R3: Flag bit 0 means the instruction must lead its group, and flag bit 1 means it must be alone in its group. A non-pseudo instruction with either bit set is accepted only when `slot_count` is 0. Otherwise it raises `hazard`.
- R4: A class-4 (condition register) instruction raises `hazard` when `slot_count` is `CR_WINDOW` (2) or more. Below that it is accepted.
- R5: Classes 1, 2, 3, 5 and 6 (fixed point, load/store, floating point, vector ALU, vector permute) raise `hazard` when `slot_count` is `GROUP_SLOTS-1` (4). Below that, each accepted instruction of these classes raises `slot_count` by one on the next cycle.
- R6: Flag bits 4:2 hold the unit class, and class 7 is a branch. A branch is accepted in any slot up to and including the last one. Accepting a branch closes the group, so `slot_count` is 0 on the next cycle.
- R7: Accepting a must-be-alone instruction closes the group, so `slot_count` is 0 on the next cycle.
- R8: `slot_count` never reaches `GROUP_SLOTS`. Filling the last slot leaves it at 0 on the next cycle.
- R9: Once a count-register-writing instruction has been accepted in the current group, an indirect branch through the count register raises `noop_req`, with `accept` and `hazard` low. If that branch also meets a hazard rule, it raises `hazard` and not `noop_req`.
- R10: `advance` closes the group. On the next cycle `slot_count` is 0 and any recorded count-register write is forgotten. This happens even if an instruction was accepted in the same cycle.
- R11: The decisions are combinational from the current state and the descriptor. At most one of `accept`, `hazard` and `noop_req` is high, all three are low while `in_valid` is low, and state changes only for an accepted instruction or `advance`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A descriptor is presented this cycle |
| in_flags | input | 5 | Bit 0 must-lead, bit 1 must-be-alone, bits 4:2 unit class |
| in_ctr_wr | input | 1 | Instruction writes the count register |
| in_ctr_br | input | 1 | Instruction branches indirectly through the count register |
| advance | input | 1 | Scheduler moves to a new cycle, closing the group |
| accept | output | 1 | Instruction joins the current group |
| hazard | output | 1 | Instruction must wait for a new group |
| noop_req | output | 1 | A no-op must be inserted before the instruction |
| slot_count | output | 3 | Slots filled in the current group |

## Verification
The bench builds the gate with the default parameters: `GROUP_SLOTS` of 5 and `CR_WINDOW` of 2. With these values the condition-register boundary is reached after two fixed-point instructions, and the last slot is reached after four mixed-class instructions. At that point the branch-only rule can be shown against vector, condition-register and branch descriptors in turn. The same short groups also carry the count-register conflict, including the case where a placement hazard must win over the no-op request, and the case where a cycle advance clears the recorded write.

// File: rtl/dgrp_pkg.sv
package dgrp_pkg;

   localparam int UNIT_W  = 3;
   localparam int FLAG_W  = UNIT_W + 2;
   localparam int NUM_CLS = 1 << UNIT_W;

   typedef enum logic [UNIT_W-1:0] {
      CLS_NONE = 3'd0,
      CLS_INT  = 3'd1,
      CLS_MEM  = 3'd2,
      CLS_FLT  = 3'd3,
      CLS_COND = 3'd4,
      CLS_VEC  = 3'd5,
      CLS_PERM = 3'd6,
      CLS_BR   = 3'd7
   } unit_cls_e;

   // Packed order follows the flag word: class in the top bits, then alone, then lead.
   typedef struct packed {
      unit_cls_e cls;
      logic      alone;
      logic      lead;
   } place_t;

   // First slot count at which a class may no longer enter the group.
   function automatic int first_blocked(input int cls, input int slots, input int crwin);
      int lim;
      case (cls)
         int'(CLS_NONE): lim = slots;       // never reached
         int'(CLS_COND): lim = crwin;
         int'(CLS_BR):   lim = slots;       // branch may take the last slot
         default:        lim = slots - 1;   // last slot is reserved for branches
      endcase
      return lim;
   endfunction

endpackage

// File: rtl/dgrp_decode.sv
module dgrp_decode
   import dgrp_pkg::*;
(
   input  logic [FLAG_W-1:0]  flags,
   output place_t             desc,
   output logic [NUM_CLS-1:0] cls_oh
);

   assign desc = place_t'(flags);

   for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
      assign cls_oh[c] = (desc.cls == UNIT_W'(c));
   end

endmodule

// File: rtl/dgrp_rules.sv
module dgrp_rules
   import dgrp_pkg::*;
#(
   parameter int GROUP_SLOTS = 5,
   parameter int CR_WINDOW   = 2,
   parameter int CNT_W       = $clog2(GROUP_SLOTS + 1)
) (
   input  logic [NUM_CLS-1:0] cls_oh,
   input  logic               lead,
   input  logic               alone,
   input  logic [CNT_W-1:0]   count,
   input  logic               ctr_set,
   input  logic               ctr_br,
   output logic               is_pseudo,
   output logic               blocked,
   output logic               want_noop,
   output logic               closes
);

   logic [NUM_CLS-1:0] cls_blk;
   logic               place_blk;

   for (genvar c = 0; c < NUM_CLS; c++) begin : g_lim
      localparam int              LIM   = first_blocked(c, GROUP_SLOTS, CR_WINDOW);
      localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIM);
      assign cls_blk[c] = cls_oh[c] & (count >= LIM_V);
   end

   assign is_pseudo = cls_oh[int'(CLS_NONE)];
   assign place_blk = (lead | alone) & (count != '0) & ~is_pseudo;
   assign blocked   = (|cls_blk) | place_blk;
   assign want_noop = ~blocked & ~is_pseudo & ctr_set & ctr_br;
   assign closes    = ~is_pseudo & (cls_oh[int'(CLS_BR)] | alone);

endmodule

// File: rtl/dgrp_track.sv
module dgrp_track #(
   parameter int GROUP_SLOTS = 5,
   parameter int CNT_W       = $clog2(GROUP_SLOTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             ends,
   input  logic             ctr_wr,
   input  logic             advance,
   output logic [CNT_W-1:0] count,
   output logic             ctr_set
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUP_SLOTS - 1);

   logic at_last;
   assign at_last = (count == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         ctr_set <= 1'b0;
      end else if (advance) begin
         count   <= '0;
         ctr_set <= 1'b0;
      end else if (take) begin
         if (ends || at_last) begin
            count   <= '0;
            ctr_set <= 1'b0;
         end else begin
            count   <= count + CNT_W'(1);
            ctr_set <= ctr_set | ctr_wr;
         end
      end
   end

endmodule

// File: rtl/dgrp_gate.sv
module dgrp_gate
   import dgrp_pkg::*;
#(
   parameter int GROUP_SLOTS = 5,
   parameter int CR_WINDOW   = 2,
   localparam int CNT_W      = $clog2(GROUP_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [FLAG_W-1:0] in_flags,
   input  logic              in_ctr_wr,
   input  logic              in_ctr_br,
   input  logic              advance,
   output logic              accept,
   output logic              hazard,
   output logic              noop_req,
   output logic [CNT_W-1:0]  slot_count
);

   if (GROUP_SLOTS < 2) begin : g_bad_slots
      $error("dgrp_gate: GROUP_SLOTS must be at least 2");
   end
   if (CR_WINDOW < 1 || CR_WINDOW > GROUP_SLOTS - 1) begin : g_bad_window
      $error("dgrp_gate: CR_WINDOW must lie in 1..GROUP_SLOTS-1");
   end

   place_t             desc;
   logic [NUM_CLS-1:0] cls_oh;
   logic [CNT_W-1:0]   count;
   logic               ctr_set;
   logic               is_pseudo, blocked, want_noop, closes;

   dgrp_decode u_decode (
      .flags  (in_flags),
      .desc   (desc),
      .cls_oh (cls_oh)
   );

   dgrp_rules #(
      .GROUP_SLOTS (GROUP_SLOTS),
      .CR_WINDOW   (CR_WINDOW),
      .CNT_W       (CNT_W)
   ) u_rules (
      .cls_oh    (cls_oh),
      .lead      (desc.lead),
      .alone     (desc.alone),
      .count     (count),
      .ctr_set   (ctr_set),
      .ctr_br    (in_ctr_br),
      .is_pseudo (is_pseudo),
      .blocked   (blocked),
      .want_noop (want_noop),
      .closes    (closes)
   );

   assign hazard   = in_valid & blocked;
   assign noop_req = in_valid & want_noop;
   assign accept   = in_valid & ~blocked & ~want_noop;

   dgrp_track #(
      .GROUP_SLOTS (GROUP_SLOTS),
      .CNT_W       (CNT_W)
   ) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (accept & ~is_pseudo),
      .ends    (closes),
      .ctr_wr  (in_ctr_wr),
      .advance (advance),
      .count   (count),
      .ctr_set (ctr_set)
   );

   assign slot_count = count;

endmodule

// File: rtl/dgrp_gate_chk.sv
module dgrp_gate_chk #(
   parameter int GROUP_SLOTS = 5,
   parameter int CR_WINDOW   = 2,
   localparam int CNT_W      = $clog2(GROUP_SLOTS + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [4:0]       in_flags,
   input logic             advance,
   input logic             accept,
   input logic             hazard,
   input logic             noop_req,
   input logic [CNT_W-1:0] slot_count
);

   logic [2:0] cls;
   logic       plain;
   assign cls   = in_flags[4:2];
   assign plain = (cls != 3'd0) && (cls != 3'd4) && (cls != 3'd7);

   assert_one_decision_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({accept, hazard, noop_req}));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!accept && !hazard && !noop_req));

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !advance) |=> $stable(slot_count));

   assert_pseudo_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cls == 3'd0) |-> accept);

   assert_pseudo_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cls == 3'd0 && !advance) |=> $stable(slot_count));

   assert_lead_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cls != 3'd0 && in_flags[1:0] != 2'b00 && slot_count != '0) |-> hazard);

   assert_cond_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cls == 3'd4 && slot_count >= CNT_W'(CR_WINDOW)) |-> hazard);

   assert_last_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && plain && slot_count == CNT_W'(GROUP_SLOTS - 1)) |-> hazard);

   assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && plain && !in_flags[1] && !advance)
      |=> slot_count == $past(slot_count) + CNT_W'(1));

   assert_branch_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cls == 3'd7) |=> slot_count == '0);

   assert_alone_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cls != 3'd0 && in_flags[1]) |=> slot_count == '0);

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      slot_count < CNT_W'(GROUP_SLOTS));

   assert_advance_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> slot_count == '0);

endmodule

bind dgrp_gate dgrp_gate_chk #(
   .GROUP_SLOTS (GROUP_SLOTS),
   .CR_WINDOW   (CR_WINDOW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_flags   (in_flags),
   .advance    (advance),
   .accept     (accept),
   .hazard     (hazard),
   .noop_req   (noop_req),
   .slot_count (slot_count)
);

// File: tb/dgrp_gate_bench.sv
module dgrp_gate_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [4:0] in_flags = '0;
   logic       in_ctr_wr = 1'b0;
   logic       in_ctr_br = 1'b0;
   logic       advance = 1'b0;
   logic       accept, hazard, noop_req;
   logic [2:0] slot_count;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dgrp_gate u_dgrp_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_flags   (in_flags),
      .in_ctr_wr  (in_ctr_wr),
      .in_ctr_br  (in_ctr_br),
      .advance    (advance),
      .accept     (accept),
      .hazard     (hazard),
      .noop_req   (noop_req),
      .slot_count (slot_count)
   );

   localparam int K_NONE = 0, K_INT = 1, K_MEM = 2, K_FLT = 3,
                  K_COND = 4, K_VEC = 5, K_PERM = 6, K_BR = 7;

   function automatic logic [4:0] fw(input int cls, input bit alone, input bit lead);
      return {cls[2:0], alone, lead};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Decision code: 1 accept, 2 hazard, 3 noop, 0 none.
   function automatic int code();
      return accept ? 1 : hazard ? 2 : noop_req ? 3 : 0;
   endfunction

   task automatic put(input bit v, input logic [4:0] f, input bit wr, input bit br, input bit adv);
      in_valid = v; in_flags = f; in_ctr_wr = wr; in_ctr_br = br; advance = adv;
      #1;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_dec(input string req, input int exp);
      chk(code() == exp && !(accept && hazard), req, "decision", code(), exp);
   endtask

   task automatic expect_cnt(input string req, input int exp);
      chk(int'(slot_count) == exp, req, "slot_count", int'(slot_count), exp);
   endtask

   task automatic issue(input int cls);
      put(1, fw(cls, 0, 0), 0, 0, 0);
      tick();
   endtask

   task automatic idle_close();
      put(0, '0, 0, 0, 1);
      tick();
      put(0, '0, 0, 0, 0);
   endtask

   task automatic t_reset();
      put(0, '0, 0, 0, 0);
      expect_cnt("R1", 0);
      put(1, fw(K_BR, 0, 0), 0, 1, 0);
      expect_dec("R1", 1);
      put(0, '0, 0, 0, 0);
   endtask

   task automatic t_pseudo();
      issue(K_INT);
      issue(K_MEM);
      put(1, fw(K_NONE, 1, 1), 0, 0, 0);
      expect_dec("R2", 1);
      tick();
      put(0, '0, 0, 0, 0);
      expect_cnt("R2", 2);
      idle_close();
   endtask

   task automatic t_lead();
      put(1, fw(K_INT, 0, 1), 0, 0, 0);
      expect_dec("R3", 1);
      tick();
      put(1, fw(K_INT, 0, 1), 0, 0, 0);
      expect_dec("R3", 2);
      put(1, fw(K_FLT, 1, 0), 0, 0, 0);
      expect_dec("R3", 2);
      put(0, fw(K_COND, 1, 1), 1, 1, 0);
      expect_dec("R11", 0);
      tick();
      expect_cnt("R11", 1);
      idle_close();
   endtask

   task automatic t_cond();
      put(1, fw(K_COND, 0, 0), 0, 0, 0);
      expect_dec("R4", 1);
      tick();
      put(1, fw(K_COND, 0, 0), 0, 0, 0);
      expect_dec("R4", 1);
      tick();
      expect_cnt("R5", 2);
      put(1, fw(K_COND, 0, 0), 0, 0, 0);
      expect_dec("R4", 2);
      put(1, fw(K_INT, 0, 0), 0, 0, 0);
      expect_dec("R4", 1);
      idle_close();
   endtask

   task automatic t_full();
      issue(K_INT);
      issue(K_FLT);
      issue(K_VEC);
      issue(K_MEM);
      put(0, '0, 0, 0, 0);
      expect_cnt("R5", 4);
      put(1, fw(K_PERM, 0, 0), 0, 0, 0);
      expect_dec("R5", 2);
      put(1, fw(K_COND, 0, 0), 0, 0, 0);
      expect_dec("R4", 2);
      put(1, fw(K_BR, 0, 0), 0, 0, 0);
      expect_dec("R6", 1);
      tick();
      put(0, '0, 0, 0, 0);
      expect_cnt("R8", 0);
   endtask

   task automatic t_branch_early();
      issue(K_INT);
      put(1, fw(K_BR, 0, 0), 0, 0, 0);
      expect_dec("R6", 1);
      tick();
      put(0, '0, 0, 0, 0);
      expect_cnt("R6", 0);
   endtask

   task automatic t_alone();
      put(1, fw(K_INT, 1, 0), 0, 0, 0);
      expect_dec("R7", 1);
      tick();
      put(0, '0, 0, 0, 0);
      expect_cnt("R7", 0);
   endtask

   task automatic t_ctr();
      put(1, fw(K_INT, 0, 0), 1, 0, 0);
      tick();
      put(1, fw(K_BR, 0, 0), 0, 1, 0);
      expect_dec("R9", 3);
      put(1, fw(K_BR, 0, 1), 0, 1, 0);
      expect_dec("R9", 2);
      put(1, fw(K_BR, 0, 0), 0, 0, 0);
      expect_dec("R9", 1);
      idle_close();
      expect_cnt("R10", 0);
      put(1, fw(K_BR, 0, 0), 0, 1, 0);
      expect_dec("R10", 1);
      put(0, '0, 0, 0, 0);
   endtask

   task automatic t_advance();
      issue(K_INT);
      issue(K_INT);
      put(1, fw(K_MEM, 0, 0), 0, 0, 1);
      expect_dec("R10", 1);
      tick();
      put(0, '0, 0, 0, 0);
      expect_cnt("R10", 0);
   endtask

   initial begin
      #20000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pseudo();
      t_lead();
      t_cond();
      t_full();
      t_branch_early();
      t_alone();
      t_ctr();
      t_advance();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule